// File: doc/BRIEF.md
# Instruction Dispatch Router

Each cycle this block receives one group of up to `GROUP_W` renamed instructions, together with a count of how many of the group's slots are valid and a set of class flags for each slot. It walks the valid slots in ascending order and decides where each instruction goes. An instruction can go to the instruction queue as a normal entry, to the instruction queue together with a load/store-queue reservation, to the instruction queue as a non-speculative entry, or nowhere: it is either dropped, or completed in place by a tail advance. The routing decision appears on per-slot strobes in the same cycle. A set of per-slot marks tells the instruction-tracking logic which status bits to set.

The block keeps its own count of instruction-queue occupancy. The issue side returns entries through a release count. The number of free entries is reported upstream every cycle. Before a slot is routed, the block compares that slot against the occupancy already raised by earlier slots of the same group. When the queue is full, the block raises a stall request, stops routing for the rest of the group, and records a full event. Six wrapping event counters record squashed drops, full events, loads, stores, non-speculative entries and plain dispatches.

Top module: `dispatch_router`

## Requirements
- R1: After reset all six event counters read 0, `iq_free` reads `IQ_DEPTH`, and with `grp_count` = 0 no strobe, mark or stall request is active.
- R2: Slots at index `grp_count` or above produce no strobe or mark and change no counter, whatever their flags are.
- R3: A slot flagged squashed raises no strobe or mark and takes no queue entry. It adds 1 to `cnt_squashed`. A squashed slot is dropped even when the queue is full, and it does not stop the group.
- R4: A load raises both `iq_insert` and `lsq_load_alloc` for its slot, takes one queue entry, and adds 1 to `cnt_load`.
- R5: A store raises both `iq_insert` and `lsq_store_alloc` for its slot, takes one queue entry, and adds 1 to `cnt_store`.
- R6: A non-speculative instruction raises `iq_insert_nonspec` and `mark_can_commit` but not `iq_insert`. It takes one queue entry and adds 1 to `cnt_nonspec`.
- R7: A nop raises `iq_tail_adv`, `mark_issued`, `mark_executed` and `mark_can_commit`. It takes no queue entry.
- R8: An instruction with no class flag raises only `iq_insert`, takes one queue entry, and adds 1 to `cnt_plain`.
- R9: When a slot carries several flags, only one of them decides the route. The order of precedence is squashed first, then load, store, non-speculative and nop. Each slot raises at most one of `iq_insert`, `iq_insert_nonspec` and `iq_tail_adv`.
- R10: When a non-squashed valid slot is examined and the occupancy has reached `IQ_DEPTH`, the block raises `stall_req` and routes neither that slot nor any later slot. `cnt_iq_full` then rises by exactly 1 on the next edge.
- R11: The full test for each slot counts the entries taken by earlier slots of the same group. The test uses the occupancy from the start of the cycle, before that cycle's release is applied.
- R12: `iq_free` equals `IQ_DEPTH` minus the occupancy and changes one edge after the strobes and release that cause the change. A release larger than the occupancy plus the new entries leaves the occupancy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_count | input | CW | Number of valid slots in this cycle's group |
| slot_squashed | input | GROUP_W | Per-slot squashed flag |
| slot_load | input | GROUP_W | Per-slot load flag |
| slot_store | input | GROUP_W | Per-slot store flag |
| slot_nonspec | input | GROUP_W | Per-slot non-speculative flag |
| slot_nop | input | GROUP_W | Per-slot nop flag |
| iq_release | input | OW | Instruction-queue entries freed this cycle |
| iq_insert | output | GROUP_W | Normal instruction-queue insert strobe per slot |
| iq_insert_nonspec | output | GROUP_W | Non-speculative insert strobe per slot |
| lsq_load_alloc | output | GROUP_W | Load entry reservation per slot |
| lsq_store_alloc | output | GROUP_W | Store entry reservation per slot |
| iq_tail_adv | output | GROUP_W | Tail-advance strobe per slot (nop) |
| mark_issued | output | GROUP_W | Set the issued status per slot |
| mark_executed | output | GROUP_W | Set the executed status per slot |
| mark_can_commit | output | GROUP_W | Set the can-commit status per slot |
| stall_req | output | 1 | Block request and upstream stall |
| iq_free | output | OW | Free instruction-queue entries |
| cnt_squashed | output | CNT_W | Squashed drop count |
| cnt_iq_full | output | CNT_W | Full event count |
| cnt_load | output | CNT_W | Loads dispatched |
| cnt_store | output | CNT_W | Stores dispatched |
| cnt_nonspec | output | CNT_W | Non-speculative entries dispatched |
| cnt_plain | output | CNT_W | Plain instructions dispatched |

## Verification
A wrong class priority or a wrong slot limit shows up as a wrong strobe or mark in the same cycle as the group. An occupancy register that drifts does not show in that cycle. It appears one edge later in `iq_free`. It also shows later in the slot where a group stops: too early if the register counts too high, too late if it counts too low. The directed cases therefore fill the queue in steps until the stop lands mid-group, next to a squashed slot. They read `iq_free` after every step. A counter that takes a wrong increment shows up on the next edge and stays wrong, so the bench checks the running totals after each case.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [2:0] {
    CLS_PLAIN   = 3'd0,
    CLS_SQUASH  = 3'd1,
    CLS_LOAD    = 3'd2,
    CLS_STORE   = 3'd3,
    CLS_NONSPEC = 3'd4,
    CLS_NOP     = 3'd5
  } slot_cls_e;

  localparam int NUM_EVT  = 6;
  localparam int EVT_SQ   = 0;
  localparam int EVT_FULL = 1;
  localparam int EVT_LD   = 2;
  localparam int EVT_ST   = 3;
  localparam int EVT_NS   = 4;
  localparam int EVT_PL   = 5;
endpackage

// File: rtl/dr_slot_class.sv
module dr_slot_class (
  input  logic              squashed,
  input  logic              is_load,
  input  logic              is_store,
  input  logic              is_nonspec,
  input  logic              is_nop,
  output dr_pkg::slot_cls_e cls
);
  // R9: fixed precedence among the flags
  always_comb begin
    if (squashed)        cls = dr_pkg::CLS_SQUASH;
    else if (is_load)    cls = dr_pkg::CLS_LOAD;
    else if (is_store)   cls = dr_pkg::CLS_STORE;
    else if (is_nonspec) cls = dr_pkg::CLS_NONSPEC;
    else if (is_nop)     cls = dr_pkg::CLS_NOP;
    else                 cls = dr_pkg::CLS_PLAIN;
  end
endmodule

// File: rtl/dr_route.sv
module dr_route #(
  parameter int GROUP_W  = 4,
  parameter int IQ_DEPTH = 16,
  localparam int CW = $clog2(GROUP_W + 1),
  localparam int OW = $clog2(IQ_DEPTH + 1)
) (
  input  logic [CW-1:0]      grp_count,
  input  dr_pkg::slot_cls_e  cls [GROUP_W],
  input  logic [OW-1:0]      occ,
  output logic [GROUP_W-1:0] ins,
  output logic [GROUP_W-1:0] ins_ns,
  output logic [GROUP_W-1:0] ld,
  output logic [GROUP_W-1:0] st,
  output logic [GROUP_W-1:0] tail,
  output logic [GROUP_W-1:0] m_iss,
  output logic [GROUP_W-1:0] m_exe,
  output logic [GROUP_W-1:0] m_cc,
  output logic [GROUP_W-1:0] drop,
  output logic               full_hit,
  output logic [CW-1:0]      n_ins
);
  logic [OW-1:0] run;
  logic          stop;

  always_comb begin
    ins = '0; ins_ns = '0; ld = '0; st = '0; tail = '0;
    m_iss = '0; m_exe = '0; m_cc = '0; drop = '0;
    full_hit = 1'b0;
    stop     = 1'b0;
    run      = occ;
    for (int i = 0; i < GROUP_W; i++) begin
      if (!stop && (i < int'(grp_count))) begin
        if (cls[i] == dr_pkg::CLS_SQUASH) begin
          drop[i] = 1'b1;
        end else if (run == OW'(IQ_DEPTH)) begin
          // R10/R11: running occupancy already holds earlier slots
          stop     = 1'b1;
          full_hit = 1'b1;
        end else begin
          unique case (cls[i])
            dr_pkg::CLS_LOAD: begin
              ins[i] = 1'b1; ld[i] = 1'b1; run = run + 1'b1;
            end
            dr_pkg::CLS_STORE: begin
              ins[i] = 1'b1; st[i] = 1'b1; run = run + 1'b1;
            end
            dr_pkg::CLS_NONSPEC: begin
              ins_ns[i] = 1'b1; m_cc[i] = 1'b1; run = run + 1'b1;
            end
            dr_pkg::CLS_NOP: begin
              tail[i] = 1'b1; m_iss[i] = 1'b1; m_exe[i] = 1'b1; m_cc[i] = 1'b1;
            end
            default: begin
              ins[i] = 1'b1; run = run + 1'b1;
            end
          endcase
        end
      end
    end
    n_ins = CW'(run - occ);
  end
endmodule

// File: rtl/dr_occ.sv
module dr_occ #(
  parameter int GROUP_W  = 4,
  parameter int IQ_DEPTH = 16,
  localparam int CW = $clog2(GROUP_W + 1),
  localparam int OW = $clog2(IQ_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] n_ins,
  input  logic [OW-1:0] rel,
  output logic [OW-1:0] occ,
  output logic [OW-1:0] free
);
  logic [OW:0]   sum;
  logic [OW-1:0] occ_nxt;
  logic          occ_en;

  always_comb begin
    sum = {1'b0, occ} + (OW+1)'(n_ins);
    if ({1'b0, rel} > sum) occ_nxt = '0;
    else                   occ_nxt = OW'(sum - {1'b0, rel});
    occ_en = (n_ins != '0) || (rel != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= '0;
    else if (occ_en) occ <= occ_nxt;
  end

  assign free = OW'(IQ_DEPTH) - occ;
endmodule

// File: rtl/dr_evcnt.sv
module dr_evcnt #(
  parameter int NUM   = 6,
  parameter int IW    = 3,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM-1:0][IW-1:0]    incr,
  output logic [NUM-1:0][CNT_W-1:0] count
);
  for (genvar k = 0; k < NUM; k++) begin : g_cnt
    logic             en;
    logic [CNT_W-1:0] nxt;
    always_comb begin
      en  = (incr[k] != '0);
      nxt = count[k] + CNT_W'(incr[k]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  count[k] <= '0;
      else if (en) count[k] <= nxt;
    end
  end
endmodule

// File: rtl/dispatch_router.sv
module dispatch_router #(
  parameter int GROUP_W  = 4,
  parameter int IQ_DEPTH = 16,
  parameter int CNT_W    = 16,
  localparam int CW = $clog2(GROUP_W + 1),
  localparam int OW = $clog2(IQ_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      grp_count,
  input  logic [GROUP_W-1:0] slot_squashed,
  input  logic [GROUP_W-1:0] slot_load,
  input  logic [GROUP_W-1:0] slot_store,
  input  logic [GROUP_W-1:0] slot_nonspec,
  input  logic [GROUP_W-1:0] slot_nop,
  input  logic [OW-1:0]      iq_release,
  output logic [GROUP_W-1:0] iq_insert,
  output logic [GROUP_W-1:0] iq_insert_nonspec,
  output logic [GROUP_W-1:0] lsq_load_alloc,
  output logic [GROUP_W-1:0] lsq_store_alloc,
  output logic [GROUP_W-1:0] iq_tail_adv,
  output logic [GROUP_W-1:0] mark_issued,
  output logic [GROUP_W-1:0] mark_executed,
  output logic [GROUP_W-1:0] mark_can_commit,
  output logic               stall_req,
  output logic [OW-1:0]      iq_free,
  output logic [CNT_W-1:0]   cnt_squashed,
  output logic [CNT_W-1:0]   cnt_iq_full,
  output logic [CNT_W-1:0]   cnt_load,
  output logic [CNT_W-1:0]   cnt_store,
  output logic [CNT_W-1:0]   cnt_nonspec,
  output logic [CNT_W-1:0]   cnt_plain
);
  dr_pkg::slot_cls_e cls [GROUP_W];
  logic [GROUP_W-1:0] drop;
  logic               full_hit;
  logic [CW-1:0]      n_ins;
  logic [OW-1:0]      occ;
  logic [dr_pkg::NUM_EVT-1:0][CW-1:0]    incr;
  logic [dr_pkg::NUM_EVT-1:0][CNT_W-1:0] count;

  for (genvar s = 0; s < GROUP_W; s++) begin : g_cls
    dr_slot_class u_cls (
      .squashed  (slot_squashed[s]),
      .is_load   (slot_load[s]),
      .is_store  (slot_store[s]),
      .is_nonspec(slot_nonspec[s]),
      .is_nop    (slot_nop[s]),
      .cls       (cls[s])
    );
  end

  dr_route #(.GROUP_W(GROUP_W), .IQ_DEPTH(IQ_DEPTH)) u_route (
    .grp_count(grp_count), .cls(cls), .occ(occ),
    .ins(iq_insert), .ins_ns(iq_insert_nonspec),
    .ld(lsq_load_alloc), .st(lsq_store_alloc), .tail(iq_tail_adv),
    .m_iss(mark_issued), .m_exe(mark_executed), .m_cc(mark_can_commit),
    .drop(drop), .full_hit(full_hit), .n_ins(n_ins)
  );

  dr_occ #(.GROUP_W(GROUP_W), .IQ_DEPTH(IQ_DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .n_ins(n_ins), .rel(iq_release),
    .occ(occ), .free(iq_free)
  );

  always_comb begin
    incr[dr_pkg::EVT_SQ]   = CW'($countones(drop));
    incr[dr_pkg::EVT_FULL] = CW'(full_hit);
    incr[dr_pkg::EVT_LD]   = CW'($countones(lsq_load_alloc));
    incr[dr_pkg::EVT_ST]   = CW'($countones(lsq_store_alloc));
    incr[dr_pkg::EVT_NS]   = CW'($countones(iq_insert_nonspec));
    incr[dr_pkg::EVT_PL]   = CW'($countones(iq_insert & ~lsq_load_alloc & ~lsq_store_alloc));
  end

  dr_evcnt #(.NUM(dr_pkg::NUM_EVT), .IW(CW), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .incr(incr), .count(count)
  );

  assign stall_req    = full_hit;
  assign cnt_squashed = count[dr_pkg::EVT_SQ];
  assign cnt_iq_full  = count[dr_pkg::EVT_FULL];
  assign cnt_load     = count[dr_pkg::EVT_LD];
  assign cnt_store    = count[dr_pkg::EVT_ST];
  assign cnt_nonspec  = count[dr_pkg::EVT_NS];
  assign cnt_plain    = count[dr_pkg::EVT_PL];
endmodule

// File: rtl/dispatch_router_chk.sv
module dispatch_router_chk #(
  parameter int GROUP_W  = 4,
  parameter int IQ_DEPTH = 16,
  parameter int CNT_W    = 16,
  localparam int CW = $clog2(GROUP_W + 1),
  localparam int OW = $clog2(IQ_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CW-1:0]      grp_count,
  input logic [GROUP_W-1:0] slot_squashed,
  input logic [OW-1:0]      iq_release,
  input logic [GROUP_W-1:0] iq_insert,
  input logic [GROUP_W-1:0] iq_insert_nonspec,
  input logic [GROUP_W-1:0] lsq_load_alloc,
  input logic [GROUP_W-1:0] lsq_store_alloc,
  input logic [GROUP_W-1:0] iq_tail_adv,
  input logic               stall_req,
  input logic [OW-1:0]      iq_free,
  input logic [CNT_W-1:0]   cnt_iq_full
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic [GROUP_W-1:0] any_strobe;
  assign any_strobe = iq_insert | iq_insert_nonspec | lsq_load_alloc
                    | lsq_store_alloc | iq_tail_adv;

  assert_free_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    iq_free <= OW'(IQ_DEPTH));

  assert_free_track_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(iq_release) == '0) |->
      (OW'($past(iq_free) - iq_free) == OW'($countones($past(iq_insert | iq_insert_nonspec)))));

  assert_load_in_iq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsq_load_alloc & ~iq_insert) == '0);

  assert_store_in_iq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lsq_store_alloc & ~iq_insert) == '0);

  assert_squash_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_squashed & any_strobe) == '0);

  assert_full_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> (cnt_iq_full == $past(cnt_iq_full) + 1'b1));

  for (genvar s = 0; s < GROUP_W; s++) begin : g_slot
    assert_one_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iq_insert[s], iq_insert_nonspec[s], iq_tail_adv[s]}));
    assert_beyond_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s >= int'(grp_count)) |-> !any_strobe[s]);
  end
endmodule

bind dispatch_router dispatch_router_chk #(
  .GROUP_W(GROUP_W), .IQ_DEPTH(IQ_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_count(grp_count), .slot_squashed(slot_squashed),
  .iq_release(iq_release), .iq_insert(iq_insert), .iq_insert_nonspec(iq_insert_nonspec),
  .lsq_load_alloc(lsq_load_alloc), .lsq_store_alloc(lsq_store_alloc),
  .iq_tail_adv(iq_tail_adv), .stall_req(stall_req), .iq_free(iq_free),
  .cnt_iq_full(cnt_iq_full)
);

// File: tb/tb_dispatch_router.sv
module tb_dispatch_router;
  localparam int GW = 4;
  localparam int DEPTH = 16;
  localparam int CNTW = 16;
  localparam int CW = $clog2(GW + 1);
  localparam int OW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] grp_count;
  logic [GW-1:0] sq, ld, st, ns, nop;
  logic [OW-1:0] rel;
  logic [GW-1:0] iq_insert, iq_insert_nonspec, lsq_load_alloc, lsq_store_alloc;
  logic [GW-1:0] iq_tail_adv, mark_issued, mark_executed, mark_can_commit;
  logic stall_req;
  logic [OW-1:0] iq_free;
  logic [CNTW-1:0] c_sq, c_full, c_ld, c_st, c_ns, c_pl;

  int n_chk = 0, n_bad = 0;
  int e_sq = 0, e_full = 0, e_ld = 0, e_st = 0, e_ns = 0, e_pl = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dispatch_router #(.GROUP_W(GW), .IQ_DEPTH(DEPTH), .CNT_W(CNTW)) dut (
    .clk(clk), .rst_n(rst_n), .grp_count(grp_count),
    .slot_squashed(sq), .slot_load(ld), .slot_store(st), .slot_nonspec(ns), .slot_nop(nop),
    .iq_release(rel), .iq_insert(iq_insert), .iq_insert_nonspec(iq_insert_nonspec),
    .lsq_load_alloc(lsq_load_alloc), .lsq_store_alloc(lsq_store_alloc),
    .iq_tail_adv(iq_tail_adv), .mark_issued(mark_issued), .mark_executed(mark_executed),
    .mark_can_commit(mark_can_commit), .stall_req(stall_req), .iq_free(iq_free),
    .cnt_squashed(c_sq), .cnt_iq_full(c_full), .cnt_load(c_ld), .cnt_store(c_st),
    .cnt_nonspec(c_ns), .cnt_plain(c_pl)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive a group at the falling edge; combinational outputs settle 1 ns later
  task automatic drive(int cnt, logic [GW-1:0] s, logic [GW-1:0] l, logic [GW-1:0] t,
                       logic [GW-1:0] n, logic [GW-1:0] p, int r);
    @(negedge clk);
    grp_count = CW'(cnt); sq = s; ld = l; st = t; ns = n; nop = p; rel = OW'(r);
    #1;
  endtask

  task automatic strobes(string req, int ins, int insns, int la, int sa, int tl,
                         int iss, int exe, int cc, int stl);
    chk(req, "iq_insert", int'(iq_insert), ins);
    chk(req, "iq_insert_nonspec", int'(iq_insert_nonspec), insns);
    chk(req, "lsq_load_alloc", int'(lsq_load_alloc), la);
    chk(req, "lsq_store_alloc", int'(lsq_store_alloc), sa);
    chk(req, "iq_tail_adv", int'(iq_tail_adv), tl);
    chk(req, "mark_issued", int'(mark_issued), iss);
    chk(req, "mark_executed", int'(mark_executed), exe);
    chk(req, "mark_can_commit", int'(mark_can_commit), cc);
    chk(req, "stall_req", int'(stall_req), stl);
  endtask

  // clock the group in, clear inputs, then check registered state
  task automatic settle(string req, int free_exp);
    @(posedge clk); #1;
    grp_count = '0; sq = '0; ld = '0; st = '0; ns = '0; nop = '0; rel = '0;
    chk(req, "iq_free", int'(iq_free), free_exp);
    chk(req, "cnt_squashed", int'(c_sq), e_sq);
    chk(req, "cnt_iq_full", int'(c_full), e_full);
    chk(req, "cnt_load", int'(c_ld), e_ld);
    chk(req, "cnt_store", int'(c_st), e_st);
    chk(req, "cnt_nonspec", int'(c_ns), e_ns);
    chk(req, "cnt_plain", int'(c_pl), e_pl);
  endtask

  task automatic t_reset_R1();
    drive(0, '1, '1, '0, '0, '0, 0);
    strobes("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    settle("R1", 16);
  endtask

  task automatic t_plain_R8();
    drive(4, '0, '0, '0, '0, '0, 0);
    strobes("R8", 'hF, 0, 0, 0, 0, 0, 0, 0, 0);
    e_pl += 4;
    settle("R8", 12);
  endtask

  task automatic t_count_limit_R2_R4();
    drive(2, '0, '1, '0, '0, '0, 0);
    strobes("R2 R4", 'h3, 0, 'h3, 0, 0, 0, 0, 0, 0);
    e_ld += 2;
    settle("R2 R4", 10);
  endtask

  task automatic t_mixed_R3_R5_R6_R7();
    // slot0 squashed+load, slot1 store, slot2 nonspec, slot3 nop
    drive(4, 4'b0001, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 0);
    strobes("R3 R5 R6 R7", 'h2, 'h4, 0, 'h2, 'h8, 'h8, 'h8, 'hC, 0);
    e_sq += 1; e_st += 1; e_ns += 1;
    settle("R3 R5 R6 R7", 8);
  endtask

  task automatic t_priority_R9();
    // slot0 load+store+nop, slot1 store+nonspec, slot2 nonspec+nop, slot3 nop
    drive(4, 4'b0000, 4'b0001, 4'b0011, 4'b0110, 4'b1101, 0);
    strobes("R9", 'h3, 'h4, 'h1, 'h2, 'h8, 'h8, 'h8, 'hC, 0);
    e_ld += 1; e_st += 1; e_ns += 1;
    settle("R9", 5);
  endtask

  task automatic t_release_R12();
    drive(0, '0, '0, '0, '0, '0, 5);
    strobes("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    settle("R12", 10);
  endtask

  task automatic t_fill_R10_R11();
    drive(4, '0, '0, '0, '0, '0, 0);
    e_pl += 4;
    settle("R11", 6);
    drive(4, '0, '0, '0, '0, '0, 0);
    e_pl += 4;
    settle("R11", 2);
    // slot0 plain takes 15th, slot1 squashed, slot2 takes 16th, slot3 stops
    drive(4, 4'b0010, '0, '0, '0, '0, 0);
    strobes("R10 R11", 'h5, 0, 0, 0, 0, 0, 0, 0, 1);
    e_pl += 2; e_sq += 1; e_full += 1;
    settle("R10 R11", 0);
  endtask

  task automatic t_full_start_R3_R10();
    // queue full: squashed slot still dropped, nop in slot1 stops the group
    drive(3, 4'b0001, '0, '0, '0, 4'b0010, 0);
    strobes("R3 R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    e_sq += 1; e_full += 1;
    settle("R3 R10", 0);
  endtask

  task automatic t_sat_release_R12();
    drive(0, '0, '0, '0, '0, '0, 20);
    settle("R12", 16);
    drive(0, '0, '0, '0, '0, '0, 0);
    strobes("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    settle("R12", 16);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    grp_count = '0; sq = '0; ld = '0; st = '0; ns = '0; nop = '0; rel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R1", "iq_free after reset", int'(iq_free), 16);
    chk("R1", "cnt_plain after reset", int'(c_pl), 0);
    t_reset_R1();
    t_plain_R8();
    t_count_limit_R2_R4();
    t_mixed_R3_R5_R6_R7();
    t_priority_R9();
    t_release_R12();
    t_fill_R10_R11();
    t_full_start_R3_R10();
    t_sat_release_R12();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule